// File: doc/BRIEF.md
# Calendar alarm match unit

The unit holds a programmable alarm made of seven calendar fields: year, month, day of month, day of week, hour, minute and second. Each field has its own enable bit. While the unit is armed, the alarm fields are compared against the live calendar values supplied by a separate time-keeping counter. A match is declared when every enabled field equals its live counterpart. Fields that are not enabled are left out of the comparison, so partial alarms are possible, for example "every day at 07:30" or "every Sunday".

The match condition is registered into a level-type raw interrupt bit. A mask enable and a software force bit combine with the raw bit to form the interrupt status, which drives the interrupt line. The alarm is programmed through a simple word-write port with a two-bit word select. The stored words, with a live match-active flag merged into the date word, are visible on read-back outputs. While the unit is armed, the hardware refuses changes to the alarm fields, so the comparison never sees a half-updated alarm.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset both alarm words, the interrupt enable, the interrupt force and the raw interrupt are all zero, and irq_o is low.
- R2: Word select 0 is the date word: year in bits 23:12, month in 11:8, day in 4:0, and the enables for day, month and year in bits 24, 25 and 26. The arm bit is bit 28. Bits that hold no field read back as zero.
- R3: Word select 1 is the time word: day of week in bits 26:24, hour in 20:16, minute in 13:8 and second in 5:0, with the enables for second, minute, hour and day of week in bits 28, 29, 30 and 31. Unused bits read back as zero.
- R4: While the stored arm bit is 1, a date-word write changes only the arm bit, and a time-word write has no effect.
- R5: Bit 29 of alm_date_o (match active) is 1 in the same cycle in which the unit is armed, at least one field enable is set, and every enabled field equals its live input. Otherwise it is 0.
- R6: With all seven field enables clear, match active stays 0 even when the unit is armed.
- R7: Match active reads 0 whenever the arm bit is 0.
- R8: int_raw_o is a register that, at each clock edge, takes the value match active had just before that edge.
- R9: irq_o equals (int_raw_o AND int_en_o) OR int_force_o.
- R10: Word select 2 writes bit 0 into the interrupt enable, and word select 3 writes bit 0 into the interrupt force. Both are read back on int_en_o and int_force_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| live_year_i | input | 12 | Live year |
| live_month_i | input | 4 | Live month |
| live_day_i | input | 5 | Live day of month |
| live_dow_i | input | 3 | Live day of week |
| live_hour_i | input | 5 | Live hour |
| live_min_i | input | 6 | Live minute |
| live_sec_i | input | 6 | Live second |
| wr_en_i | input | 1 | Word write strobe |
| wr_sel_i | input | 2 | Word select: 0 date, 1 time, 2 interrupt enable, 3 interrupt force |
| wr_data_i | input | 32 | Write data |
| alm_date_o | output | 32 | Stored date word with match active in bit 29 |
| alm_time_o | output | 32 | Stored time word |
| int_raw_o | output | 1 | Raw interrupt (registered match) |
| int_en_o | output | 1 | Interrupt enable |
| int_force_o | output | 1 | Interrupt force |
| irq_o | output | 1 | Interrupt line (masked status) |

## Verification
The hardest situation to reach is a write that lands while the unit is armed and carries new field values. In that case the fields must stay as they were while the arm bit alone follows the data. The bench arms a partial alarm and then writes both words with different contents, first with the arm bit set and then with it clear. Because the live match is combinational but the raw bit is registered, the bench also changes live values in the middle of a cycle and samples before the next edge, so the one-cycle lag of the raw bit is observed directly. A long phase of random writes and live values from small value sets drives frequent coincidences and checks every output against a behavioural model on each clock.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int FIELD_W    = 12;
  localparam int WORD_W     = 32;

  localparam int YEAR_W  = 12;
  localparam int MONTH_W = 4;
  localparam int DAY_W   = 5;
  localparam int DOW_W   = 3;
  localparam int HOUR_W  = 5;
  localparam int MIN_W   = 6;
  localparam int SEC_W   = 6;

  localparam int F_SEC   = 0;
  localparam int F_MIN   = 1;
  localparam int F_HOUR  = 2;
  localparam int F_DOW   = 3;
  localparam int F_DAY   = 4;
  localparam int F_MONTH = 5;
  localparam int F_YEAR  = 6;

  localparam int WORD_DATE  = 0;
  localparam int WORD_TIME  = 1;
  localparam int ARM_BIT    = 28;
  localparam int ACTIVE_BIT = 29;

  localparam logic [1:0] SEL_DATE  = 2'd0;
  localparam logic [1:0] SEL_TIME  = 2'd1;
  localparam logic [1:0] SEL_INTEN = 2'd2;
  localparam logic [1:0] SEL_FORCE = 2'd3;

  function automatic int fld_word(input int f);
    return (f >= F_DAY) ? WORD_DATE : WORD_TIME;
  endfunction

  function automatic int fld_width(input int f);
    case (f)
      F_SEC:   return SEC_W;
      F_MIN:   return MIN_W;
      F_HOUR:  return HOUR_W;
      F_DOW:   return DOW_W;
      F_DAY:   return DAY_W;
      F_MONTH: return MONTH_W;
      default: return YEAR_W;
    endcase
  endfunction

  function automatic int fld_lsb(input int f);
    case (f)
      F_SEC:   return 0;
      F_MIN:   return 8;
      F_HOUR:  return 16;
      F_DOW:   return 24;
      F_DAY:   return 0;
      F_MONTH: return 8;
      default: return 12;
    endcase
  endfunction

  function automatic int fld_en_bit(input int f);
    case (f)
      F_SEC:   return 28;
      F_MIN:   return 29;
      F_HOUR:  return 30;
      F_DOW:   return 31;
      F_DAY:   return 24;
      F_MONTH: return 25;
      default: return 26;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] word_mask(input int w);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int f = 0; f < NUM_FIELDS; f++) begin
      if (fld_word(f) == w) begin
        m = m | (((WORD_W'(1) << fld_width(f)) - WORD_W'(1)) << fld_lsb(f));
        m[fld_en_bit(f)] = 1'b1;
      end
    end
    if (w == WORD_DATE) m[ARM_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
  import cal_alarm_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [1:0]                    wr_sel_i,
  input  logic [WORD_W-1:0]             wr_data_i,
  output logic [WORD_W-1:0]             date_word_o,
  output logic [WORD_W-1:0]             time_word_o,
  output logic [NUM_FIELDS*FIELD_W-1:0] alm_flat_o,
  output logic [NUM_FIELDS-1:0]         fld_en_o,
  output logic                          arm_o,
  output logic                          int_en_o,
  output logic                          int_force_o
);
  localparam logic [WORD_W-1:0] DATE_MASK = word_mask(WORD_DATE);
  localparam logic [WORD_W-1:0] TIME_MASK = word_mask(WORD_TIME);
  localparam logic [WORD_W-1:0] ARM_MASK  = WORD_W'(1) << ARM_BIT;

  logic [WORD_W-1:0] date_q, time_q;
  logic              int_en_q, force_q;
  logic              armed;

  assign armed = date_q[ARM_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      date_q   <= '0;
      time_q   <= '0;
      int_en_q <= 1'b0;
      force_q  <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        SEL_DATE: begin
          // fields frozen while armed; only the arm bit follows
          if (armed) date_q[ARM_BIT] <= wr_data_i[ARM_BIT];
          else       date_q          <= wr_data_i & DATE_MASK;
        end
        SEL_TIME:  if (!armed) time_q <= wr_data_i & TIME_MASK;
        SEL_INTEN: int_en_q <= wr_data_i[0];
        default:   force_q  <= wr_data_i[0];
      endcase
    end
  end

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_unpack
    localparam int LSB = fld_lsb(f);
    localparam int W   = fld_width(f);
    localparam int EB  = fld_en_bit(f);
    if (fld_word(f) == WORD_DATE) begin : g_date
      assign alm_flat_o[f*FIELD_W +: FIELD_W] = FIELD_W'(date_q[LSB +: W]);
      assign fld_en_o[f] = date_q[EB];
    end else begin : g_time
      assign alm_flat_o[f*FIELD_W +: FIELD_W] = FIELD_W'(time_q[LSB +: W]);
      assign fld_en_o[f] = time_q[EB];
    end
  end

  assign date_word_o = date_q;
  assign time_word_o = time_q;
  assign arm_o       = armed;
  assign int_en_o    = int_en_q;
  assign int_force_o = force_q;

  AST_LOCK_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && wr_en_i && wr_sel_i == SEL_TIME) |=> $stable(time_q)); // R4
  AST_LOCK_DATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && wr_en_i && wr_sel_i == SEL_DATE) |=> $stable(date_q & ~ARM_MASK)); // R4
  AST_DATE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (date_q & ~DATE_MASK) == '0); // R2
  AST_TIME_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (time_q & ~TIME_MASK) == '0); // R3
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_FIELDS*FIELD_W-1:0] alm_flat_i,
  input  logic [NUM_FIELDS*FIELD_W-1:0] live_flat_i,
  input  logic [NUM_FIELDS-1:0]         fld_en_i,
  input  logic                          arm_i,
  output logic                          match_o
);
  logic [NUM_FIELDS-1:0] fld_ok;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_lane
    assign fld_ok[f] = !fld_en_i[f] ||
                       (alm_flat_i[f*FIELD_W +: FIELD_W] == live_flat_i[f*FIELD_W +: FIELD_W]);
  end

  assign match_o = arm_i && (|fld_en_i) && (&fld_ok);

  AST_NO_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fld_en_i == '0) |-> !match_o); // R6
  AST_DISARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |-> !match_o); // R7
endmodule

// File: rtl/cal_alarm_irq.sv
module cal_alarm_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  input  logic int_en_i,
  input  logic force_i,
  output logic raw_o,
  output logic irq_o
);
  logic raw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= 1'b0;
    else         raw_q <= match_i;
  end

  assign raw_o = raw_q;
  assign irq_o = (raw_q & int_en_i) | force_i;

  AST_RAW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |=> raw_o); // R8
  AST_RAW_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_i |=> !raw_o); // R8
  AST_FORCE_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |-> irq_o); // R9
  AST_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_i && !int_en_i) |-> !irq_o); // R9
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [YEAR_W-1:0]  live_year_i,
  input  logic [MONTH_W-1:0] live_month_i,
  input  logic [DAY_W-1:0]   live_day_i,
  input  logic [DOW_W-1:0]   live_dow_i,
  input  logic [HOUR_W-1:0]  live_hour_i,
  input  logic [MIN_W-1:0]   live_min_i,
  input  logic [SEC_W-1:0]   live_sec_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  output logic [WORD_W-1:0]  alm_date_o,
  output logic [WORD_W-1:0]  alm_time_o,
  output logic               int_raw_o,
  output logic               int_en_o,
  output logic               int_force_o,
  output logic               irq_o
);
  logic [NUM_FIELDS*FIELD_W-1:0] alm_flat, live_flat;
  logic [NUM_FIELDS-1:0]         fld_en;
  logic [WORD_W-1:0]             date_word;
  logic                          arm, match, int_en, int_force;

  assign live_flat[F_SEC*FIELD_W   +: FIELD_W] = FIELD_W'(live_sec_i);
  assign live_flat[F_MIN*FIELD_W   +: FIELD_W] = FIELD_W'(live_min_i);
  assign live_flat[F_HOUR*FIELD_W  +: FIELD_W] = FIELD_W'(live_hour_i);
  assign live_flat[F_DOW*FIELD_W   +: FIELD_W] = FIELD_W'(live_dow_i);
  assign live_flat[F_DAY*FIELD_W   +: FIELD_W] = FIELD_W'(live_day_i);
  assign live_flat[F_MONTH*FIELD_W +: FIELD_W] = FIELD_W'(live_month_i);
  assign live_flat[F_YEAR*FIELD_W  +: FIELD_W] = FIELD_W'(live_year_i);

  cal_alarm_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .date_word_o (date_word),
    .time_word_o (alm_time_o),
    .alm_flat_o  (alm_flat),
    .fld_en_o    (fld_en),
    .arm_o       (arm),
    .int_en_o    (int_en),
    .int_force_o (int_force)
  );

  cal_alarm_cmp u_cmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alm_flat_i  (alm_flat),
    .live_flat_i (live_flat),
    .fld_en_i    (fld_en),
    .arm_i       (arm),
    .match_o     (match)
  );

  cal_alarm_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .match_i  (match),
    .int_en_i (int_en),
    .force_i  (int_force),
    .raw_o    (int_raw_o),
    .irq_o    (irq_o)
  );

  always_comb begin
    alm_date_o             = date_word;
    alm_date_o[ACTIVE_BIT] = match;
  end

  assign int_en_o    = int_en;
  assign int_force_o = int_force;

  AST_ACTIVE_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alm_date_o[ACTIVE_BIT] |-> alm_date_o[ARM_BIT]); // R7
endmodule

// File: tb/cal_alarm_match_bench.sv
`timescale 1ns/1ps
module cal_alarm_match_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] l_year = '0;
  logic [3:0]  l_month = '0;
  logic [4:0]  l_day = '0;
  logic [2:0]  l_dow = '0;
  logic [4:0]  l_hour = '0;
  logic [5:0]  l_min = '0;
  logic [5:0]  l_sec = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] alm_date, alm_time;
  logic        int_raw, int_en, int_force, irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // reference model state
  logic [31:0] m_date = '0, m_time = '0;
  bit m_ien = 0, m_force = 0, m_raw = 0;

  always #5 clk = ~clk;

  cal_alarm_match u_cal_alarm_match (
    .clk_i(clk), .rst_ni(rst_n),
    .live_year_i(l_year), .live_month_i(l_month), .live_day_i(l_day),
    .live_dow_i(l_dow), .live_hour_i(l_hour), .live_min_i(l_min), .live_sec_i(l_sec),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .alm_date_o(alm_date), .alm_time_o(alm_time), .int_raw_o(int_raw),
    .int_en_o(int_en), .int_force_o(int_force), .irq_o(irq)
  );

  function automatic bit m_match();
    bit ok;
    bit any;
    ok  = 1;
    any = m_date[24] | m_date[25] | m_date[26] | m_time[28] | m_time[29] | m_time[30] | m_time[31];
    if (m_date[24] && m_date[4:0]   != l_day)   ok = 0;
    if (m_date[25] && m_date[11:8]  != l_month) ok = 0;
    if (m_date[26] && m_date[23:12] != l_year)  ok = 0;
    if (m_time[28] && m_time[5:0]   != l_sec)   ok = 0;
    if (m_time[29] && m_time[13:8]  != l_min)   ok = 0;
    if (m_time[30] && m_time[20:16] != l_hour)  ok = 0;
    if (m_time[31] && m_time[26:24] != l_dow)   ok = 0;
    return m_date[28] && any && ok;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [31:0] ed;
    ed = m_date;
    ed[29] = m_match();
    chk("R5 date word", alm_date, ed);
    chk("R3 time word", alm_time, m_time);
    chk("R8 raw", {31'd0, int_raw}, {31'd0, m_raw});
    chk("R10 enable", {31'd0, int_en}, {31'd0, m_ien});
    chk("R10 force", {31'd0, int_force}, {31'd0, m_force});
    chk("R9 irq", {31'd0, irq}, {31'd0, (m_raw & m_ien) | m_force});
  endtask

  task automatic tick();
    bit mt;
    @(posedge clk);
    mt = m_match();
    if (wr_en) begin
      case (wr_sel)
        2'd0: if (m_date[28]) m_date[28] = wr_data[28];
              else m_date = wr_data & 32'h17FF_FF1F;
        2'd1: if (!m_date[28]) m_time = wr_data & 32'hF71F_3F3F;
        2'd2: m_ien = wr_data[0];
        default: m_force = wr_data[0];
      endcase
    end
    m_raw = mt;
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic set_live(input int y, input int mo, input int d, input int dw,
                          input int h, input int mi, input int s);
    l_year = 12'(y); l_month = 4'(mo); l_day = 5'(d); l_dow = 3'(dw);
    l_hour = 5'(h); l_min = 6'(mi); l_sec = 6'(s);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 date", alm_date, 32'h0);
    chk("R1 time", alm_time, 32'h0);
    chk("R1 irq", {29'd0, int_raw, irq, int_en | int_force}, 32'h0);
    tick();

    // R2 / R3 layout and masking
    wr(2'd0, 32'hEFFF_FFFF);
    chk("R2 date mask", alm_date, 32'h07FF_FF1F);
    wr(2'd1, 32'hFFFF_FFFF);
    chk("R3 time mask", alm_time, 32'hF71F_3F3F);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0);

    // R5 partial alarm: hour 10, minute 30; month stored but not enabled
    wr(2'd1, (32'd1 << 30) | (32'd1 << 29) | (32'd10 << 16) | (32'd30 << 8));
    wr(2'd0, (32'd1 << 28) | (32'd3 << 8));
    wr(2'd2, 32'd1);
    set_live(2000, 7, 9, 2, 10, 29, 0);
    tick();
    chk("R5 no match min 29", {31'd0, alm_date[29]}, 32'd0);
    set_live(2000, 7, 9, 2, 10, 30, 15);
    #1;
    chk("R5 match same cycle", {31'd0, alm_date[29]}, 32'd1);
    chk("R8 raw lags", {31'd0, int_raw}, 32'd0);
    tick();
    chk("R8 raw set", {31'd0, int_raw}, 32'd1);
    chk("R9 irq on", {31'd0, irq}, 32'd1);
    set_live(2000, 7, 9, 2, 11, 30, 15);
    tick();
    chk("R5 wrong hour", {31'd0, alm_date[29]}, 32'd0);
    chk("R8 raw clear", {31'd0, int_raw}, 32'd0);
    set_live(2000, 7, 9, 2, 10, 30, 0);
    tick();

    // R4 lock while armed
    wr(2'd1, 32'h0000_0505);
    chk("R4 time locked", alm_time, 32'h600A_1E00);
    wr(2'd0, (32'd1 << 28) | (32'd7 << 8) | 32'd5);
    chk("R4 date locked", alm_date & 32'hDFFF_FFFF, 32'h1000_0300);
    wr(2'd0, 32'h0000_0000);
    chk("R4 only arm cleared", alm_date, 32'h0000_0300);
    chk("R7 disarmed no match", {31'd0, alm_date[29]}, 32'd0);
    tick();
    chk("R7 raw low", {31'd0, int_raw}, 32'd0);

    // R6 no field enables
    wr(2'd1, 32'h000A_1E00);
    wr(2'd0, 32'h1000_0000);
    repeat (3) tick();
    chk("R6 no enables", {30'd0, alm_date[29], int_raw}, 32'd0);
    wr(2'd0, 32'h0);

    // R9 / R10 force and mask
    wr(2'd2, 32'd0);
    wr(2'd3, 32'd1);
    chk("R10 force readback", {31'd0, int_force}, 32'd1);
    chk("R9 forced irq", {31'd0, irq}, 32'd1);
    wr(2'd3, 32'd0);
    chk("R9 released", {31'd0, irq}, 32'd0);

    // R5 all seven fields
    wr(2'd1, 32'hF000_0000 | (32'd4 << 24) | (32'd23 << 16) | (32'd59 << 8) | 32'd58);
    wr(2'd0, 32'h1700_0000 | (32'd2024 << 12) | (32'd2 << 8) | 32'd29);
    set_live(2024, 2, 29, 4, 23, 59, 58);
    tick();
    chk("R5 full match", {31'd0, alm_date[29]}, 32'd1);
    set_live(2025, 2, 29, 4, 23, 59, 58);
    tick();
    chk("R5 year differs", {31'd0, alm_date[29]}, 32'd0);
    wr(2'd0, 32'h0);

    // random phase, compared to the model every clock
    for (int i = 0; i < 4000; i++) begin
      set_live($urandom_range(0, 1), $urandom_range(1, 2), $urandom_range(1, 2),
               $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 2),
               $urandom_range(0, 2));
      if ($urandom_range(0, 9) == 0) begin
        logic [31:0] d;
        logic [1:0]  s;
        d = $urandom();
        s = 2'($urandom_range(0, 3));
        if (s == 2'd0) begin
          d[23:12] = 12'($urandom_range(0, 1));
          d[11:8]  = 4'($urandom_range(1, 2));
          d[4:0]   = 5'($urandom_range(1, 2));
        end else if (s == 2'd1) begin
          d[26:24] = 3'($urandom_range(0, 1));
          d[20:16] = 5'($urandom_range(0, 1));
          d[13:8]  = 6'($urandom_range(0, 2));
          d[5:0]   = 6'($urandom_range(0, 2));
        end
        wr(s, d);
      end else begin
        tick();
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule